// File: doc/BRIEF.md
# Status Channel Calendar Sequencer

This block produces the flow-control status stream that a packet receiver returns to its transmitter. Each slot of the stream carries one 2-bit symbol. A programmable calendar lists port numbers. The sequencer walks that calendar entry by entry and, for each entry, sends the current 2-bit FIFO fill status of the port named there. A port that appears in several calendar entries is reported several times per pass, so it receives credit updates more often than a port listed only once.

The calendar pass is repeated a programmable number of times. A parity symbol then closes the sequence, followed by a framing symbol that opens the next one. A full sequence therefore spans `len * rep + 2` slots. In the slow mode each slot is held for four data clocks. In the fast mode a new slot starts on every data clock. The calendar contents, its length and the repeat count may only be changed while the sequencer is disabled. Enabling the sequencer starts the stream at a framing slot.

Top module: `scs_status_seq`

## Requirements
- R1: While `enable` is low, `stat_sym` is 2'b11 and `slot_strobe` is 0. This holds from the first clock edge that samples `enable` low, including when a slot is only partly sent.
- R2: The clock edge that first samples `enable` high starts a framing slot. After that edge, `stat_sym` is 2'b11 and `slot_strobe` is 1.
- R3: Slots follow a fixed order with a period of `cal_len*cal_rep + 2`. The order is: framing (2'b11), then `cal_len*cal_rep` port slots that walk calendar entries 0 to `cal_len-1` once per repeat, then one parity slot.
- R4: With `fast_mode` low, every slot lasts exactly four clocks. `slot_strobe` is high only in the first clock of each slot.
- R5: With `fast_mode` high, a new slot starts on every clock, and `slot_strobe` stays high.
- R6: A port slot for calendar entry i sends the status of port p. Here p is `cal_table[i*PORT_W +: PORT_W]`, and the status of port p is `port_status[2*p +: 2]`. The same port may appear in any number of entries.
- R7: A port slot never sends 2'b11. A port status of 2'b11 is sent as 2'b10.
- R8: The parity slot sends the bitwise inverse of the XOR of all port-slot symbols sent since the previous framing slot. The XOR uses the symbols after the R7 substitution.
- R9: The symbol of a slot is captured in its first clock and held for the whole slot, even if `port_status` changes during the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the sequencer; low holds it idle at framing |
| fast_mode | input | 1 | 1: one clock per slot; 0: four clocks per slot |
| cal_len | input | LEN_W | Number of calendar entries in use (1 to MAX_CAL) |
| cal_rep | input | REP_W | Calendar passes per sequence (1 or more) |
| cal_table | input | MAX_CAL*PORT_W | Calendar entries; entry i holds a port number |
| port_status | input | 2*NUM_PORTS | 2-bit FIFO status of each port |
| stat_sym | output | 2 | Status symbol of the current slot |
| slot_strobe | output | 1 | High in the first clock of each slot |

## Verification
The checker attached to the top tracks the slot count of every sequence. On every cycle it checks:
- framing appears exactly every `cal_len*cal_rep + 2` slots;
- no port slot carries the framing code;
- the parity slot matches its own running XOR of the port symbols;
- the symbol is held between strobes;
- the idle output, the start at framing, and the strobe spacing in both modes.

Which port's status a given slot carries, the remapping of a 2'b11 status, and the holding of a slot while the status inputs churn can only be shown by the bench's scenarios. These scenarios compare each slot against a sequence the bench computes from the table and the status values.

// File: rtl/scs_pkg.sv
package scs_pkg;

   typedef enum logic [1:0] {
      PH_FRAME  = 2'd0,
      PH_PORT   = 2'd1,
      PH_PARITY = 2'd2
   } phase_e;

   localparam logic [1:0] SYM_FRAME = 2'b11;
   localparam logic [1:0] SYM_CLAMP = 2'b10;

endpackage

// File: rtl/scs_slot_timer.sv
module scs_slot_timer #(
   parameter int SLOW_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fast_mode,
   output logic slot_go
);

   generate
      if (SLOW_DIV < 1) begin : g_bad_div
         $error("scs_slot_timer: SLOW_DIV must be at least 1");
      end

      if (SLOW_DIV == 1) begin : g_no_div
         logic unused_fast;
         assign unused_fast = fast_mode;
         assign slot_go     = enable;
      end else begin : g_div
         localparam int DIV_W = $clog2(SLOW_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (!enable || fast_mode) begin
               div_q <= '0;
            end else if (div_q == DIV_LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign slot_go = enable && (fast_mode || (div_q == '0));
      end
   endgenerate

endmodule

// File: rtl/scs_cal_walker.sv
module scs_cal_walker
   import scs_pkg::*;
#(
   parameter int MAX_CAL = 32,
   parameter int REP_W   = 4,
   localparam int IDX_W  = $clog2(MAX_CAL),
   localparam int LEN_W  = $clog2(MAX_CAL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             slot_go,
   input  logic [LEN_W-1:0] cal_len,
   input  logic [REP_W-1:0] cal_rep,
   output phase_e           phase,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(MAX_CAL - 1);

   generate
      if (MAX_CAL < 2) begin : g_bad_cal
         $error("scs_cal_walker: MAX_CAL must be at least 2");
      end
      if (REP_W < 1) begin : g_bad_rep
         $error("scs_cal_walker: REP_W must be at least 1");
      end
   endgenerate

   phase_e           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [REP_W-1:0] rep_q;
   logic [LEN_W:0]   idx_inc;
   logic [REP_W:0]   rep_inc;
   logic             idx_last;
   logic             rep_last;

   // Compare with >= so that a zero length or repeat count acts as one.
   assign idx_inc  = (LEN_W + 1)'(idx_q) + 1'b1;
   assign rep_inc  = {1'b0, rep_q} + 1'b1;
   assign idx_last = (idx_inc >= {1'b0, cal_len}) || (idx_q == IDX_MAX);
   assign rep_last = (rep_inc >= {1'b0, cal_rep});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FRAME;
         idx_q   <= '0;
         rep_q   <= '0;
      end else if (!enable) begin
         phase_q <= PH_FRAME;
         idx_q   <= '0;
         rep_q   <= '0;
      end else if (slot_go) begin
         unique case (phase_q)
            PH_FRAME: begin
               phase_q <= PH_PORT;
               idx_q   <= '0;
               rep_q   <= '0;
            end
            PH_PORT: begin
               if (idx_last) begin
                  idx_q <= '0;
                  if (rep_last) begin
                     phase_q <= PH_PARITY;
                     rep_q   <= '0;
                  end else begin
                     rep_q <= rep_q + 1'b1;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_PARITY: begin
               phase_q <= PH_FRAME;
            end
            default: begin
               phase_q <= PH_FRAME;
            end
         endcase
      end
   end

   assign phase = phase_q;
   assign idx   = idx_q;

endmodule

// File: rtl/scs_dip2.sv
module scs_dip2 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       accum,
   input  logic [1:0] sym_in,
   output logic [1:0] parity
);

   logic [1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (accum) begin
         acc_q <= acc_q ^ sym_in;
      end
   end

   assign parity = ~acc_q;

endmodule

// File: rtl/scs_status_seq.sv
module scs_status_seq
   import scs_pkg::*;
#(
   parameter int NUM_PORTS = 16,
   parameter int MAX_CAL   = 32,
   parameter int REP_W     = 4,
   parameter int SLOW_DIV  = 4,
   localparam int PORT_W   = $clog2(NUM_PORTS),
   localparam int IDX_W    = $clog2(MAX_CAL),
   localparam int LEN_W    = $clog2(MAX_CAL + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic                        fast_mode,
   input  logic [LEN_W-1:0]            cal_len,
   input  logic [REP_W-1:0]            cal_rep,
   input  logic [MAX_CAL*PORT_W-1:0]   cal_table,
   input  logic [2*NUM_PORTS-1:0]      port_status,
   output logic [1:0]                  stat_sym,
   output logic                        slot_strobe
);

   generate
      if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
         $error("scs_status_seq: NUM_PORTS must be a power of two, at least 2");
      end
   endgenerate

   logic             slot_go;
   phase_e           phase;
   logic [IDX_W-1:0] idx;
   logic [1:0]       parity;
   logic [PORT_W-1:0] entry [MAX_CAL];
   logic [1:0]       pstat [NUM_PORTS];
   logic [PORT_W-1:0] sel_port;
   logic [1:0]       raw_stat;
   logic [1:0]       port_sym;
   logic [1:0]       sym_nxt;
   logic [1:0]       sym_q;
   logic             strobe_q;

   scs_slot_timer #(
      .SLOW_DIV (SLOW_DIV)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .fast_mode (fast_mode),
      .slot_go   (slot_go)
   );

   scs_cal_walker #(
      .MAX_CAL (MAX_CAL),
      .REP_W   (REP_W)
   ) u_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .slot_go (slot_go),
      .cal_len (cal_len),
      .cal_rep (cal_rep),
      .phase   (phase),
      .idx     (idx)
   );

   for (genvar g = 0; g < MAX_CAL; g++) begin : g_entry
      assign entry[g] = cal_table[g*PORT_W +: PORT_W];
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pstat
      assign pstat[p] = port_status[2*p +: 2];
   end

   assign sel_port = entry[idx];
   assign raw_stat = pstat[sel_port];
   assign port_sym = (raw_stat == SYM_FRAME) ? SYM_CLAMP : raw_stat;

   always_comb begin
      unique case (phase)
         PH_FRAME:  sym_nxt = SYM_FRAME;
         PH_PORT:   sym_nxt = port_sym;
         PH_PARITY: sym_nxt = parity;
         default:   sym_nxt = SYM_FRAME;
      endcase
   end

   scs_dip2 u_dip2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!enable || (slot_go && phase == PH_FRAME)),
      .accum  (slot_go && phase == PH_PORT),
      .sym_in (port_sym),
      .parity (parity)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_q    <= SYM_FRAME;
         strobe_q <= 1'b0;
      end else if (!enable) begin
         sym_q    <= SYM_FRAME;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= slot_go;
         if (slot_go) begin
            sym_q <= sym_nxt;
         end
      end
   end

   assign stat_sym    = sym_q;
   assign slot_strobe = strobe_q;

endmodule

// File: rtl/scs_status_seq_chk.sv
module scs_status_seq_chk #(
   parameter int NUM_PORTS = 16,
   parameter int MAX_CAL   = 32,
   parameter int REP_W     = 4,
   localparam int LEN_W    = $clog2(MAX_CAL + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             fast_mode,
   input logic [LEN_W-1:0] cal_len,
   input logic [REP_W-1:0] cal_rep,
   input logic [1:0]       stat_sym,
   input logic             slot_strobe
);

   int         len_eff;
   int         rep_eff;
   int         port_slots;
   int         cnt;
   logic [1:0] acc;

   assign len_eff    = (cal_len == '0) ? 1 : int'(cal_len);
   assign rep_eff    = (cal_rep == '0) ? 1 : int'(cal_rep);
   assign port_slots = len_eff * rep_eff;

   // cnt counts slots sent since the last framing slot, that slot included.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= 0;
         acc <= '0;
      end else if (!enable) begin
         cnt <= 0;
         acc <= '0;
      end else if (slot_strobe) begin
         if (cnt == 0 || cnt == port_slots + 2) begin
            cnt <= 1;
            acc <= '0;
         end else begin
            cnt <= cnt + 1;
            if (cnt <= port_slots) begin
               acc <= acc ^ stat_sym;
            end
         end
      end
   end

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (stat_sym == 2'b11 && !slot_strobe));

   p_start_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> (slot_strobe && stat_sym == 2'b11));

   p_frame_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_strobe && (cnt == 0 || cnt == port_slots + 2)) |-> stat_sym == 2'b11);

   p_slow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_strobe && !fast_mode) |=> !slot_strobe);

   p_fast_every_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fast_mode) |=> slot_strobe);

   p_port_not_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_strobe && cnt >= 1 && cnt <= port_slots) |-> stat_sym != 2'b11);

   p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_strobe && cnt == port_slots + 1) |-> stat_sym == ~acc);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !slot_strobe) |-> $stable(stat_sym));

endmodule

bind scs_status_seq scs_status_seq_chk #(
   .NUM_PORTS (NUM_PORTS),
   .MAX_CAL   (MAX_CAL),
   .REP_W     (REP_W)
) u_chk (.*);

// File: tb/scs_status_seq_tb.sv
module scs_status_seq_tb;

   localparam int NP = 4;
   localparam int MC = 8;
   localparam int RW = 3;
   localparam int PW = 2;
   localparam int LW = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             fast_mode = 1'b0;
   logic [LW-1:0]    cal_len = '0;
   logic [RW-1:0]    cal_rep = '0;
   logic [MC*PW-1:0] cal_table;
   logic [2*NP-1:0]  port_status;
   logic [1:0]       stat_sym;
   logic             slot_strobe;

   logic [PW-1:0] tbl [MC];
   logic [1:0]    st  [NP];

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < MC; i++) cal_table[i*PW +: PW] = tbl[i];
      for (int i = 0; i < NP; i++) port_status[2*i +: 2] = st[i];
   end

   scs_status_seq #(
      .NUM_PORTS (NP),
      .MAX_CAL   (MC),
      .REP_W     (RW),
      .SLOW_DIV  (4)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .fast_mode   (fast_mode),
      .cal_len     (cal_len),
      .cal_rep     (cal_rep),
      .cal_table   (cal_table),
      .port_status (port_status),
      .stat_sym    (stat_sym),
      .slot_strobe (slot_strobe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic churn_status();
      for (int i = 0; i < NP; i++) st[i] = 2'($urandom);
   endtask

   // Runs one configuration and compares every slot with a computed sequence.
   task automatic run(input int len, input int m, input bit fast, input int nslots,
                      input bit churn);
      logic [1:0] acc;
      logic [1:0] exp_sym;
      logic [1:0] held;
      int         period;
      int         pos;
      int         gap;
      string      req;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      fast_mode = fast;
      cal_len   = LW'(len);
      cal_rep   = RW'(m);
      chk(stat_sym == 2'b11 && !slot_strobe, "R1 idle", int'({slot_strobe, stat_sym}), 3);
      enable = 1'b1;
      acc    = '0;
      period = len * m + 2;
      for (int k = 0; k < nslots; k++) begin
         gap = 0;
         do begin
            @(negedge clk);
            gap++;
         end while (!slot_strobe && gap < 12);
         req = (k == 0) ? "R2 start" : (fast ? "R5 fast spacing" : "R4 slow spacing");
         chk(gap == 1, req, gap, 1);
         pos = k % period;
         if (pos == 0) begin
            exp_sym = 2'b11;
            acc     = '0;
            req     = "R3 framing";
         end else if (pos == period - 1) begin
            exp_sym = ~acc;
            req     = "R8 parity";
         end else begin
            exp_sym = st[tbl[(pos - 1) % len]];
            req     = "R6 port status";
            if (exp_sym == 2'b11) begin
               exp_sym = 2'b10;
               req     = "R7 clamp";
            end
            acc = acc ^ exp_sym;
         end
         chk(stat_sym == exp_sym, req, stat_sym, exp_sym);
         held = stat_sym;
         if (churn) churn_status();
         if (!fast) begin
            for (int j = 0; j < 3; j++) begin
               @(negedge clk);
               chk(stat_sym == held && !slot_strobe, "R9 hold", int'({slot_strobe, stat_sym}),
                   int'(held));
               if (churn) churn_status();
            end
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MC; i++) tbl[i] = '0;
      for (int i = 0; i < NP; i++) st[i] = 2'(i);
      repeat (3) @(negedge clk);
      chk(stat_sym == 2'b11 && !slot_strobe, "R1 reset", int'({slot_strobe, stat_sym}), 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stat_sym == 2'b11 && !slot_strobe, "R1 after reset", int'({slot_strobe, stat_sym}), 3);

      // Sweep over length, repeat count and mode with a spread table.
      for (int len = 1; len <= 4; len++) begin
         for (int m = 1; m <= 3; m++) begin
            for (int f = 0; f < 2; f++) begin
               for (int i = 0; i < MC; i++) tbl[i] = PW'((i * 3 + len) % NP);
               for (int i = 0; i < NP; i++) st[i] = 2'((i + len + m) % 4);
               run(len, m, f[0], 2 * (len * m + 2) + 3, 1'b0);
            end
         end
      end

      // One port listed in scattered entries, status churning each clock.
      for (int i = 0; i < MC; i++) tbl[i] = (i % 2 == 0) ? PW'(3) : PW'(i % NP);
      run(5, 2, 1'b0, 30, 1'b1);
      run(5, 2, 1'b1, 30, 1'b1);

      // Full-size calendar with the largest repeat count.
      for (int i = 0; i < MC; i++) tbl[i] = PW'(MC - 1 - i);
      run(MC, 7, 1'b1, 2 * (MC * 7 + 2) + 2, 1'b1);
      run(MC, 2, 1'b0, 40, 1'b1);

      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(stat_sym == 2'b11 && !slot_strobe, "R1 final idle", int'({slot_strobe, stat_sym}), 3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule